// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block is the device-side bus front end of a NOR-style parallel flash. Every rising edge of the internal sampling clock `clk`, it samples the active-low pins: reset, chip enable, output enable, write enable and address-valid. It also samples the external bus clock. From these samples it classifies the bus cycle and drives the data-bus enable, the data direction and the WAIT pin for that cycle class.

A dual-mode address latch holds the address that reads and writes act on.

- **Async mode:** the latch is transparent while address-valid is low and holds once it rises.
- **Sync mode:** the first qualifying event captures the address. That event is either a bus-clock rising edge with address-valid low, or the address-valid rising edge.

Read data comes from a computed word array stand-in. When a write cycle ends, a one-cycle strobe carries the latched address and the bus data toward a command interface.

The cycle classifier is a state machine whose next state is the class of the pins sampled at the edge. The states are:

| State | Pin condition |
|---|---|
| `ST_RESET` | reset low |
| `ST_STANDBY` | CE high |
| `ST_OUTDIS` | CE low, OE high, WE high |
| `ST_READ` | CE low, OE low, WE high |
| `ST_WRITE` | CE low, OE high, WE low |
| `ST_INVALID` | CE low, OE low, WE low |

The transitions are:

- **enter_reset:** any state moves to `ST_RESET` asynchronously when the reset pin falls.
- **Classification:** every other transition, including a state to itself, goes to the class of the pins sampled at that edge.
- **Named cases:** `begin_read` (to `ST_READ`), `end_write` (from `ST_WRITE` to any other state, which fires the strobe) and `go_idle` (to `ST_STANDBY` or `ST_OUTDIS`).

Outputs follow the registered state, so they change one `clk` edge after the pins are sampled.

Top module: `pflash_bus_front`

## Requirements
- R1: While `bus_rst_n` is low, `dq_oe`, `wait_oe` and `wr_stb` are 0 and `lat_addr` is 0, regardless of every other input.
- R2: With `bus_ce_n` high (standby), nothing is driven and `dq_dir_in` is 0. Address-valid changes do not alter `lat_addr`, and a write-enable pulse produces no strobe.
- R3: One edge after the pins show CE low, OE low and WE high, `dq_oe` is 1. `dq_out` equals `{lat_addr[7:0] ^ 8'h5A, ~lat_addr[7:0]}`, and is 0 while `dq_oe` is 0.
- R4: One edge after the pins show CE low, WE low and OE high, `dq_dir_in` is 1 while `dq_oe` and `wait_oe` are 0.
- R5: One edge after the pins show CE low with OE and WE high, `dq_oe`, `dq_dir_in` and `wait_oe` are all 0.
- R6: With CE, OE and WE all low (invalid cycle), nothing is driven, `dq_dir_in` is 0, and raising WE afterwards issues no strobe.
- R7: WAIT is driven (`wait_oe`=1) only in a read. In async mode `wait_val` is 0. In sync mode `wait_val` is 1 in the first read cycle and 0 in the cycles after it.
- R8: In async mode with CE low, `lat_addr` takes `bus_addr` at each edge where address-valid is sampled low. It holds its value while address-valid is high.
- R9: In sync mode, a bus-clock rising edge seen with address-valid low captures `bus_addr`. Further bus-clock edges do not recapture until address-valid has been high and then low again.
- R10: In sync mode, if no bus-clock edge captured during the low phase, the sample where address-valid is first seen high captures `bus_addr`. No sync capture happens while WE is low.
- R11: `blk_idx` equals the top 3 bits of `lat_addr`.
- R12: At the first edge where WE is sampled high after a write cycle, `wr_stb` pulses for exactly one cycle. In that cycle `wr_addr` is the latched address and `wr_data` is `dq_in` as sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| bus_rst_n | input | 1 | Reset pin, active low, asynchronous |
| sync_mode | input | 1 | 1 selects synchronous address capture and WAIT |
| bus_clk | input | 1 | External bus clock, sampled for rising edges |
| bus_adv_n | input | 1 | Address-valid, active low |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 16 | Address pins |
| dq_in | input | 16 | Data bus input side |
| dq_out | output | 16 | Data bus output side |
| dq_oe | output | 1 | Data bus output driver enable |
| dq_dir_in | output | 1 | 1 while the data bus is an input (write) |
| wait_oe | output | 1 | WAIT driver enable (0 = high impedance) |
| wait_val | output | 1 | WAIT level, active high |
| lat_addr | output | 16 | Latched address |
| blk_idx | output | 3 | Block index from the high address bits |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 16 | Address carried by the strobe |
| wr_data | output | 16 | Data carried by the strobe |

## Verification
The hardest situation to reach is the sync-mode rule that exactly one capture happens per address-valid low phase. This needs a bus-clock edge followed by further edges that must be ignored, and then a second low phase in which the address-valid rise itself captures.

The bench toggles `bus_clk` by hand from the stimulus sequence and changes `bus_addr` between every event. A wrong capture therefore shows up as a different `lat_addr`. It also runs a sync capture attempt during a write, to show that a low WE blocks the capture without using up the pending capture.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_STANDBY,
        ST_OUTDIS,
        ST_READ,
        ST_WRITE,
        ST_INVALID
    } pfb_state_e;

    // Word array stand-in: contents computed from the low address byte.
    function automatic logic [15:0] pfb_word(input logic [7:0] idx);
        return {idx ^ 8'h5A, ~idx};
    endfunction

    function automatic pfb_state_e pfb_classify(input logic ce_n,
                                                input logic oe_n,
                                                input logic we_n);
        if (ce_n)
            return ST_STANDBY;
        else if (!oe_n && !we_n)
            return ST_INVALID;
        else if (!oe_n)
            return ST_READ;
        else if (!we_n)
            return ST_WRITE;
        else
            return ST_OUTDIS;
    endfunction

endpackage

// File: rtl/pfb_cycle_fsm.sv
module pfb_cycle_fsm
    import pfb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic       we_n,
    input  logic       sync_mode,
    output pfb_state_e state,
    output logic       dq_oe,
    output logic       dq_dir_in,
    output logic       wait_oe,
    output logic       wait_val
);

    pfb_state_e prev_state;

    // State register: next state is the class of the sampled pins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_RESET;
            prev_state <= ST_RESET;
        end else begin
            prev_state <= state;
            state      <= pfb_classify(ce_n, oe_n, we_n);
        end
    end

    // Output decode from the registered state.
    always_comb begin
        dq_oe     = 1'b0;
        dq_dir_in = 1'b0;
        wait_oe   = 1'b0;
        wait_val  = 1'b0;
        unique case (state)
            ST_READ: begin
                dq_oe    = 1'b1;
                wait_oe  = 1'b1;
                wait_val = sync_mode && (prev_state != ST_READ);
            end
            ST_WRITE: dq_dir_in = 1'b1;
            ST_RESET, ST_STANDBY, ST_OUTDIS, ST_INVALID: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/pfb_addr_latch.sv
module pfb_addr_latch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              bus_clk,
    input  logic              adv_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] lat_addr
);

    logic adv_q;
    logic bclk_q;
    logic armed;
    logic adv_rise;
    logic bclk_rise;
    logic sync_qual;

    assign adv_rise  = !adv_q && adv_n;
    assign bclk_rise = !bclk_q && bus_clk;
    assign sync_qual = !ce_n && we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr <= '0;
            adv_q    <= 1'b1;
            bclk_q   <= 1'b1;
            armed    <= 1'b1;
        end else begin
            adv_q  <= adv_n;
            bclk_q <= bus_clk;
            if (!sync_mode) begin
                if (!ce_n && !adv_n)
                    lat_addr <= addr_in;
                armed <= 1'b1;
            end else begin
                if (sync_qual) begin
                    if (adv_rise && armed) begin
                        lat_addr <= addr_in;
                    end else if (bclk_rise && !adv_n && armed) begin
                        lat_addr <= addr_in;
                        armed    <= 1'b0;
                    end
                end
                if (adv_n)
                    armed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pfb_write_strobe.sv
module pfb_write_strobe
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pfb_state_e        state,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    logic write_end;
    assign write_end = (state == ST_WRITE) && we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= write_end;
            if (write_end) begin
                wr_addr <= lat_addr;
                wr_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/pflash_bus_front.sv
module pflash_bus_front
    import pfb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 3
) (
    input  logic              clk,
    input  logic              bus_rst_n,
    input  logic              sync_mode,
    input  logic              bus_clk,
    input  logic              bus_adv_n,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              dq_dir_in,
    output logic              wait_oe,
    output logic              wait_val,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [BLK_W-1:0]  blk_idx,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int IDX_W = 8;

    pfb_state_e state;
    logic [15:0] word;

    pfb_cycle_fsm u_fsm (
        .clk       (clk),
        .rst_n     (bus_rst_n),
        .ce_n      (bus_ce_n),
        .oe_n      (bus_oe_n),
        .we_n      (bus_we_n),
        .sync_mode (sync_mode),
        .state     (state),
        .dq_oe     (dq_oe),
        .dq_dir_in (dq_dir_in),
        .wait_oe   (wait_oe),
        .wait_val  (wait_val)
    );

    pfb_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk       (clk),
        .rst_n     (bus_rst_n),
        .sync_mode (sync_mode),
        .bus_clk   (bus_clk),
        .adv_n     (bus_adv_n),
        .ce_n      (bus_ce_n),
        .we_n      (bus_we_n),
        .addr_in   (bus_addr),
        .lat_addr  (lat_addr)
    );

    pfb_write_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wstb (
        .clk      (clk),
        .rst_n    (bus_rst_n),
        .state    (state),
        .we_n     (bus_we_n),
        .lat_addr (lat_addr),
        .dq_in    (dq_in),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    assign word    = pfb_word(lat_addr[IDX_W-1:0]);
    assign dq_out  = dq_oe ? DATA_W'(word) : '0;
    assign blk_idx = lat_addr[ADDR_W-1 -: BLK_W];

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              bus_rst_n,
    input logic              bus_ce_n,
    input logic              bus_oe_n,
    input logic              bus_we_n,
    input logic              dq_oe,
    input logic              dq_dir_in,
    input logic              wait_oe,
    input logic              wr_stb,
    input logic [DATA_W-1:0] dq_out
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !bus_rst_n |-> (!dq_oe && !wait_oe && !wr_stb));

    a_r4_no_contention: assert property (@(posedge clk) disable iff (!bus_rst_n)
        !(dq_oe && dq_dir_in));

    a_r3_read_needs_pins: assert property (@(posedge clk) disable iff (!bus_rst_n)
        dq_oe |-> $past(!bus_ce_n && !bus_oe_n && bus_we_n));

    a_r7_wait_only_in_read: assert property (@(posedge clk) disable iff (!bus_rst_n)
        wait_oe |-> dq_oe);

    a_r12_strobe_single: assert property (@(posedge clk) disable iff (!bus_rst_n)
        wr_stb |=> !wr_stb);

    a_r12_strobe_after_we_rise: assert property (@(posedge clk) disable iff (!bus_rst_n)
        wr_stb |-> ($past(bus_we_n) && !$past(bus_we_n, 2)));

    a_r3_idle_bus_zero: assert property (@(posedge clk) disable iff (!bus_rst_n)
        !dq_oe |-> (dq_out == '0));

endmodule

bind pflash_bus_front pfb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .bus_rst_n (bus_rst_n),
    .bus_ce_n  (bus_ce_n),
    .bus_oe_n  (bus_oe_n),
    .bus_we_n  (bus_we_n),
    .dq_oe     (dq_oe),
    .dq_dir_in (dq_dir_in),
    .wait_oe   (wait_oe),
    .wr_stb    (wr_stb),
    .dq_out    (dq_out)
);

// File: tb/pflash_bus_front_tb_top.sv
module pflash_bus_front_tb_top;

    logic        clk = 1'b0;
    logic        bus_rst_n, sync_mode, bus_clk, bus_adv_n;
    logic        bus_ce_n, bus_oe_n, bus_we_n;
    logic [15:0] bus_addr, dq_in, dq_out, lat_addr, wr_addr, wr_data;
    logic        dq_oe, dq_dir_in, wait_oe, wait_val, wr_stb;
    logic [2:0]  blk_idx;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    pflash_bus_front dut_i (
        .clk(clk), .bus_rst_n(bus_rst_n), .sync_mode(sync_mode), .bus_clk(bus_clk),
        .bus_adv_n(bus_adv_n), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n), .bus_addr(bus_addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .dq_dir_in(dq_dir_in), .wait_oe(wait_oe), .wait_val(wait_val),
        .lat_addr(lat_addr), .blk_idx(blk_idx), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    // {ce_n, oe_n, we_n, exp dq_oe, exp dq_dir_in, exp wait_oe}
    localparam logic [5:0] VEC [8] = '{
        6'b100_000,   // R2 standby
        6'b111_000,   // R2 standby
        6'b001_101,   // R3 read
        6'b010_010,   // R4 write
        6'b011_000,   // R5 output disable
        6'b000_000,   // R6 invalid
        6'b001_101,   // R3 read
        6'b101_000    // R2 standby
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input logic [15:0] a);
        return {a[7:0] ^ 8'h5A, ~a[7:0]};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bus_rst_n = 0; sync_mode = 0; bus_clk = 0; bus_adv_n = 0;
        bus_ce_n = 0; bus_oe_n = 0; bus_we_n = 1; bus_addr = 16'hA355; dq_in = 16'h0;
        tick(); tick();
        // R1: reset overrides a read setup
        chk("R1 dq_oe", dq_oe, 0);
        chk("R1 wait_oe", wait_oe, 0);
        chk("R1 lat_addr", lat_addr, 0);
        bus_oe_n = 1; bus_adv_n = 1;
        bus_rst_n = 1;
        tick();

        // R8: async transparent latch then hold
        bus_adv_n = 0; bus_addr = 16'h6A12;
        tick();
        chk("R8 follow1", lat_addr, 16'h6A12);
        bus_addr = 16'hE7C4;
        tick();
        chk("R8 follow2", lat_addr, 16'hE7C4);
        chk("R11 blk_idx", blk_idx, 3'b111);
        bus_adv_n = 1; tick();
        bus_addr = 16'h1111; tick();
        chk("R8 hold", lat_addr, 16'hE7C4);

        // Table walk: cycle classification
        for (int i = 0; i < 8; i++) begin
            {bus_ce_n, bus_oe_n, bus_we_n} = VEC[i][5:3];
            tick();
            chk("R2-6 vec dq_oe", dq_oe, VEC[i][2]);
            chk("R4 vec dir", dq_dir_in, VEC[i][1]);
            chk("R7 vec wait_oe", wait_oe, VEC[i][0]);
            if (VEC[i][2]) begin
                chk("R3 data", dq_out, word_of(16'hE7C4));
                chk("R7 async wait_val", wait_val, 0);
            end else begin
                chk("R3 idle data", dq_out, 0);
            end
        end

        // R2: standby ignores address-valid and write pulses
        bus_ce_n = 1; bus_oe_n = 1; bus_we_n = 0; bus_adv_n = 0; bus_addr = 16'h2222;
        tick();
        bus_we_n = 1; tick();
        chk("R2 no latch", lat_addr, 16'hE7C4);
        chk("R2 no strobe", wr_stb, 0);
        tick();
        chk("R2 no strobe2", wr_stb, 0);
        bus_adv_n = 1;

        // R12: write strobe
        bus_ce_n = 0; bus_oe_n = 1; bus_we_n = 0; dq_in = 16'hBEEF;
        tick();
        chk("R4 write dir", dq_dir_in, 1);
        bus_we_n = 1;
        tick();
        chk("R12 strobe", wr_stb, 1);
        chk("R12 addr", wr_addr, 16'hE7C4);
        chk("R12 data", wr_data, 16'hBEEF);
        dq_in = 16'h0;
        tick();
        chk("R12 one cycle", wr_stb, 0);

        // R6: invalid cycle then WE rises: no drive, no strobe
        bus_oe_n = 0; bus_we_n = 0;
        tick();
        chk("R6 no drive", dq_oe, 0);
        bus_oe_n = 1; bus_we_n = 1;
        tick();
        chk("R6 no strobe", wr_stb, 0);
        tick();
        chk("R6 no strobe2", wr_stb, 0);

        // R9: sync capture on bus clock edge, no recapture
        sync_mode = 1; bus_adv_n = 0; bus_addr = 16'h3C01;
        tick();
        chk("R9 no capture before edge", lat_addr, 16'hE7C4);
        bus_clk = 1; tick();
        chk("R9 clk capture", lat_addr, 16'h3C01);
        bus_clk = 0; bus_addr = 16'h4D02; tick();
        bus_clk = 1; tick();
        chk("R9 no recapture", lat_addr, 16'h3C01);
        bus_clk = 0; bus_addr = 16'h5E03; bus_adv_n = 1; tick();
        chk("R9 rise after capture ignored", lat_addr, 16'h3C01);

        // R10: blocked during write, then capture on address-valid rise
        bus_adv_n = 0; bus_we_n = 0; bus_addr = 16'h8F04; tick();
        bus_clk = 1; tick();
        chk("R10 blocked by WE", lat_addr, 16'h3C01);
        bus_we_n = 1; bus_clk = 0; bus_addr = 16'h9A05; tick();
        tick();  // strobe from write end passes
        bus_adv_n = 1; tick();
        chk("R10 adv rise capture", lat_addr, 16'h9A05);
        chk("R11 blk_idx sync", blk_idx, 3'b100);

        // R7: sync read WAIT
        bus_oe_n = 0; tick();
        chk("R7 sync wait_oe", wait_oe, 1);
        chk("R7 sync wait first", wait_val, 1);
        chk("R3 sync data", dq_out, word_of(16'h9A05));
        tick();
        chk("R7 sync wait later", wait_val, 0);
        bus_oe_n = 1; tick();
        chk("R7 wait released", wait_oe, 0);

        // R1: async reset mid read
        bus_oe_n = 0; tick();
        bus_rst_n = 0; #1;
        chk("R1 async clear", dq_oe, 0);
        chk("R1 latch clear", lat_addr, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule